// File: doc/BRIEF.md
# Parallel Converter Handshake Driver

This block sits on the host side of an 8-bit parallel analog-to-digital converter. The converter offers two handshake styles, and the block drives its chip-select, write-strobe and read-strobe lines for either one. A client asks for a conversion with a valid/ready request that carries a style bit and an early-read bit. The driver runs the strobe sequence and waits for the converter to report completion. It then samples the data bus and the over-range line and returns the result with a one-cycle valid pulse.

In write-then-read style the driver pulses the write strobe to start sampling. It then waits for the interrupt line to fall before it opens the read strobe. With early read selected, it instead opens the read strobe a fixed number of cycles after the write pulse, ahead of the converter's internal timeout. The converter then latches its result on that read edge.

In read-only style the driver holds the read strobe low from the start. It takes completion as the ready line released (high) together with the interrupt line low. After every transfer, and after every abort, the driver releases chip select and read so that the interrupt clears. It then keeps the converter idle for a recovery gap. A watchdog aborts a conversion whose completion never arrives.

Top module: `conv_host_ctrl`

## Requirements
- R1: After reset, and at any time the driver is idle, `csN`, `wrN` and `rdN` are all high, `reqReady` is high and `rspValid` is low; `reqReady` is high only while idle.
- R2: `csN` is low in every cycle in which `wrN` or `rdN` is low.
- R3: In write-then-read style (`reqMode`=1) the write strobe is low for exactly `WR_PULSE` consecutive cycles, and `rdN` is high throughout that pulse.
- R4: In write-then-read style without early read (`reqEarly`=0), `rdN` does not fall until `intN` has been seen low.
- R5: In write-then-read style with early read (`reqEarly`=1), `rdN` falls after exactly `EARLY_DELAY` cycles in which chip select is low and both strobes are high, following the rising edge of the write strobe, whatever the state of `intN`.
- R6: In read-only style (`reqMode`=0) the write strobe never falls. The read strobe falls at the start of the conversion, and completion is accepted only when `rdyN` is high and `intN` is low in the same cycle.
- R7: `RD_ACCESS` cycles after completion is accepted, the driver samples `dataIn` and `oflN` with the read strobe still low. It then gives one single-cycle `rspValid` pulse, with `rspData` equal to the sampled bus and `rspOverRange` = NOT `oflN` (the converter's over-range line is active low).
- R8: In the cycle in which `rspValid` or `rspError` is high, `csN` and `rdN` are both high.
- R9: After a transfer or an abort, `reqReady` stays low for exactly `RECOVERY_CYC` cycles, counted from the cycle of the `rspValid`/`rspError` pulse, and chip select stays high for all of them.
- R10: If completion is not seen within `TIMEOUT_CYC` cycles of waiting, the driver ends the conversion with a single-cycle `rspError` pulse and no `rspValid` pulse.
- R11: A request presented while `reqReady` is low is ignored: it starts no conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Conversion request |
| reqReady | output | 1 | High when a request is accepted (idle) |
| reqMode | input | 1 | 1 = write-then-read style, 0 = read-only style |
| reqEarly | input | 1 | 1 = open read before the internal timeout (write-then-read style only) |
| rspValid | output | 1 | One-cycle result pulse |
| rspError | output | 1 | One-cycle watchdog abort pulse |
| rspData | output | DATA_W | Sampled conversion result |
| rspOverRange | output | 1 | Input was above full scale |
| csN | output | 1 | Converter chip select, active low |
| wrN | output | 1 | Converter write strobe, active low |
| rdN | output | 1 | Converter read strobe, active low |
| intN | input | 1 | Converter completion interrupt, active low |
| rdyN | input | 1 | Converter busy line, low while converting (pulled high when released) |
| dataIn | input | DATA_W | Converter data bus |
| oflN | input | 1 | Converter over-range line, active low |

## Verification
The hardest situations to reach from the ports are the ones that depend on the converter's own timing. These are the early read, which must land before the converter's internal timeout, and the watchdog abort, which needs a converter that never finishes. The bench therefore contains a cycle-level model of the converter. Its completion latency, result word, over-range bit and a stuck option are set for each test. The model latches its result on a read falling edge that comes before its timeout, and it counts those early captures so the bench can confirm that the shortcut was taken. It drives the inverse word onto the bus while the read strobe is high, so a sample taken at the wrong moment shows up as wrong data.

// File: rtl/conv_host_pkg.sv
package conv_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WR_PULSE,
    ST_EARLY_GAP,
    ST_WAIT_INT,
    ST_READ_WAIT,
    ST_READ_HOLD,
    ST_RECOVER
  } convState_t;

  typedef struct packed {
    logic latchReq;
    logic clrPhase;
    logic clrWatch;
    logic runWatch;
    logic capture;
    logic finishOk;
    logic finishErr;
  } dpStrobe_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/conv_host_ctrl_dp.sv
module conv_host_ctrl_dp
  import conv_host_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PH_W        = 6,
  parameter int WD_W        = 9,
  parameter int TIMEOUT_CYC = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              reqMode,
  input  logic              reqEarly,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              oflN,
  output logic              modeWr,
  output logic              earlyRd,
  output logic [PH_W-1:0]   phaseCnt,
  output logic              watchExpired,
  output logic              rspValid,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData,
  output logic              rspOverRange
);

  localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};
  localparam logic [WD_W-1:0] WD_MAX = {WD_W{1'b1}};

  logic [WD_W-1:0] watchCnt;

  // request attributes held for the whole conversion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeWr  <= 1'b0;
      earlyRd <= 1'b0;
    end else if (strobe.latchReq) begin
      modeWr  <= reqMode;
      earlyRd <= reqMode & reqEarly;
    end
  end

  // shared phase timer for pulse widths, gaps and recovery
  always_ff @(posedge clk) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strobe.clrPhase)  phaseCnt <= '0;
    else if (phaseCnt != PH_MAX) phaseCnt <= phaseCnt + 1'b1;
  end

  // completion watchdog, advances only while waiting
  always_ff @(posedge clk) begin
    if (!rstN)                 watchCnt <= '0;
    else if (strobe.clrWatch)  watchCnt <= '0;
    else if (strobe.runWatch && watchCnt != WD_MAX) watchCnt <= watchCnt + 1'b1;
  end

  assign watchExpired = (int'(watchCnt) >= TIMEOUT_CYC - 1);

  // result capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData      <= '0;
      rspOverRange <= 1'b0;
    end else if (strobe.capture) begin
      rspData      <= dataIn;
      rspOverRange <= ~oflN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspValid <= strobe.finishOk;
      rspError <= strobe.finishErr;
    end
  end

endmodule

// File: rtl/conv_host_ctrl_fsm.sv
module conv_host_ctrl_fsm
  import conv_host_pkg::*;
#(
  parameter int PH_W         = 6,
  parameter int WR_PULSE     = 4,
  parameter int EARLY_DELAY  = 6,
  parameter int RD_ACCESS    = 3,
  parameter int RECOVERY_CYC = 50
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            modeWr,
  input  logic            earlyRd,
  input  logic [PH_W-1:0] phaseCnt,
  input  logic            watchExpired,
  input  logic            intN,
  input  logic            rdyN,
  output dpStrobe_t       strobe,
  output logic            reqReady,
  output logic            csN,
  output logic            wrN,
  output logic            rdN
);

  convState_t state, nextState;
  logic       doneSeen;
  int         phase;

  assign phase = int'(phaseCnt);

  // completion condition depends on handshake style
  assign doneSeen = modeWr ? ~intN : (rdyN & ~intN);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          nextState       = ST_SETUP;
        end
      end
      ST_SETUP: begin
        strobe.clrPhase = 1'b1;
        strobe.clrWatch = 1'b1;
        nextState       = modeWr ? ST_WR_PULSE : ST_READ_WAIT;
      end
      ST_WR_PULSE: begin
        if (phase == WR_PULSE - 1) begin
          strobe.clrPhase = 1'b1;
          nextState       = earlyRd ? ST_EARLY_GAP : ST_WAIT_INT;
        end
      end
      ST_EARLY_GAP: begin
        if (phase == EARLY_DELAY - 1) begin
          strobe.clrPhase = 1'b1;
          nextState       = ST_READ_WAIT;
        end
      end
      ST_WAIT_INT: begin
        strobe.runWatch = 1'b1;
        if (!intN) begin
          nextState = ST_READ_WAIT;
        end else if (watchExpired) begin
          strobe.finishErr = 1'b1;
          strobe.clrPhase  = 1'b1;
          nextState        = ST_RECOVER;
        end
      end
      ST_READ_WAIT: begin
        strobe.runWatch = 1'b1;
        if (doneSeen) begin
          strobe.clrPhase = 1'b1;
          nextState       = ST_READ_HOLD;
        end else if (watchExpired) begin
          strobe.finishErr = 1'b1;
          strobe.clrPhase  = 1'b1;
          nextState        = ST_RECOVER;
        end
      end
      ST_READ_HOLD: begin
        if (phase == RD_ACCESS - 1) begin
          strobe.capture  = 1'b1;
          strobe.finishOk = 1'b1;
          strobe.clrPhase = 1'b1;
          nextState       = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (phase == RECOVERY_CYC - 1) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // converter lines decoded from the registered state
  always_comb begin
    reqReady = (state == ST_IDLE);
    csN      = (state == ST_IDLE) || (state == ST_RECOVER);
    wrN      = (state != ST_WR_PULSE);
    rdN      = !((state == ST_READ_WAIT) || (state == ST_READ_HOLD));
  end

endmodule

// File: rtl/conv_host_ctrl.sv
module conv_host_ctrl
  import conv_host_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int WR_PULSE     = 4,
  parameter int EARLY_DELAY  = 6,
  parameter int RD_ACCESS    = 3,
  parameter int RECOVERY_CYC = 50,
  parameter int TIMEOUT_CYC  = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqMode,
  input  logic              reqEarly,
  output logic              rspValid,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData,
  output logic              rspOverRange,
  output logic              csN,
  output logic              wrN,
  output logic              rdN,
  input  logic              intN,
  input  logic              rdyN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              oflN
);

  localparam int PH_MAX_VAL = maxOf4(WR_PULSE, EARLY_DELAY, RD_ACCESS, RECOVERY_CYC);
  localparam int PH_W       = $clog2(PH_MAX_VAL + 1);
  localparam int WD_W       = $clog2(TIMEOUT_CYC + 1);

  dpStrobe_t       strobe;
  logic            modeWr;
  logic            earlyRd;
  logic [PH_W-1:0] phaseCnt;
  logic            watchExpired;

  conv_host_ctrl_fsm #(
    .PH_W(PH_W), .WR_PULSE(WR_PULSE), .EARLY_DELAY(EARLY_DELAY),
    .RD_ACCESS(RD_ACCESS), .RECOVERY_CYC(RECOVERY_CYC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeWr(modeWr),
    .earlyRd(earlyRd), .phaseCnt(phaseCnt), .watchExpired(watchExpired),
    .intN(intN), .rdyN(rdyN), .strobe(strobe), .reqReady(reqReady),
    .csN(csN), .wrN(wrN), .rdN(rdN)
  );

  conv_host_ctrl_dp #(
    .DATA_W(DATA_W), .PH_W(PH_W), .WD_W(WD_W), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqMode(reqMode),
    .reqEarly(reqEarly), .dataIn(dataIn), .oflN(oflN), .modeWr(modeWr),
    .earlyRd(earlyRd), .phaseCnt(phaseCnt), .watchExpired(watchExpired),
    .rspValid(rspValid), .rspError(rspError), .rspData(rspData),
    .rspOverRange(rspOverRange)
  );

endmodule

// File: rtl/conv_host_ctrl_chk.sv
module conv_host_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic csN,
  input logic wrN,
  input logic rdN,
  input logic rspValid,
  input logic rspError
);

  AST_CS_COVERS_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN || !rdN) |-> !csN);                                   // R2

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (csN && wrN && rdN && !rspValid));              // R1

  AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> rdN);                                               // R3

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);                                     // R7

  AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || rspError) |-> (csN && rdN));                    // R8

  AST_RECOVER_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> !reqReady);                                   // R9

  AST_ERROR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> (!rspValid ##1 !rspError));                     // R10

endmodule

bind conv_host_ctrl conv_host_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .csN(csN), .wrN(wrN),
  .rdN(rdN), .rspValid(rspValid), .rspError(rspError)
);

// File: tb/conv_host_ctrl_test.sv
module conv_host_ctrl_test;

  localparam int WR_P   = 4;
  localparam int EARLY  = 6;
  localparam int RDACC  = 3;
  localparam int RECOV  = 50;
  localparam int TOUT   = 400;

  // vector: [18] style, [17] early, [16:9] data, [8] over-range, [7:0] latency
  localparam int NVEC = 6;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'hA5, 1'b0, 8'd20},
    {1'b1, 1'b1, 8'h3C, 1'b1, 8'd80},
    {1'b0, 1'b0, 8'h81, 1'b0, 8'd25},
    {1'b0, 1'b0, 8'hFF, 1'b1, 8'd10},
    {1'b1, 1'b0, 8'h00, 1'b1, 8'd5},
    {1'b1, 1'b1, 8'h7E, 1'b0, 8'd60}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqMode = 1'b0, reqEarly = 1'b0;
  logic reqReady, rspValid, rspError, rspOverRange;
  logic [7:0] rspData;
  logic csN, wrN, rdN, intN, rdyN, oflN;
  logic [7:0] dataIn;

  // converter model controls
  logic       simWrMode = 1'b1;
  logic       simStuck  = 1'b0;
  logic [7:0] simData   = 8'h00;
  logic       simOvr    = 1'b0;
  int         simLat    = 10;

  int nTests = 0, nFail = 0;

  always #5 clk = ~clk;

  conv_host_ctrl #(
    .DATA_W(8), .WR_PULSE(WR_P), .EARLY_DELAY(EARLY), .RD_ACCESS(RDACC),
    .RECOVERY_CYC(RECOV), .TIMEOUT_CYC(TOUT)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqEarly(reqEarly), .rspValid(rspValid),
    .rspError(rspError), .rspData(rspData), .rspOverRange(rspOverRange),
    .csN(csN), .wrN(wrN), .rdN(rdN), .intN(intN), .rdyN(rdyN),
    .dataIn(dataIn), .oflN(oflN)
  );

  // ---------------- converter model ----------------
  logic mBusy, prevCs, prevRd, prevWr;
  int   mCnt;
  int   earlyHitTotal;

  always @(posedge clk) begin
    prevCs <= csN; prevRd <= rdN; prevWr <= wrN;
    if (!rstN) begin
      intN <= 1'b1; mBusy <= 1'b0; mCnt <= 0; earlyHitTotal <= 0;
      prevCs <= 1'b1; prevRd <= 1'b1; prevWr <= 1'b1;
    end else begin
      if ((csN && !prevCs) || (rdN && !prevRd)) intN <= 1'b1;
      if (simWrMode) begin
        if (wrN && !prevWr && !csN) begin
          mBusy <= 1'b1; mCnt <= 0;
        end else if (mBusy) begin
          if (!rdN && prevRd && !csN) begin
            mBusy <= 1'b0; intN <= 1'b0; earlyHitTotal <= earlyHitTotal + 1;
          end else if (mCnt == simLat - 1 && !simStuck) begin
            mBusy <= 1'b0; intN <= 1'b0;
          end else mCnt <= mCnt + 1;
        end
      end else begin
        if (!rdN && prevRd && !csN) begin
          mBusy <= 1'b1; mCnt <= 0;
        end else if (mBusy) begin
          if (mCnt == simLat - 1 && !simStuck) begin
            mBusy <= 1'b0; intN <= 1'b0;
          end else mCnt <= mCnt + 1;
        end
      end
    end
  end

  assign rdyN   = !(!simWrMode && !csN && mBusy);
  assign dataIn = (!csN && !rdN) ? simData : ~simData;
  assign oflN   = !simOvr;

  // ---------------- pin monitors ----------------
  int wrRun = 0, lastWrWidth = 0, gap = 0, lastGap = 0;
  bit afterWr = 1'b0;
  int wrLowTotal = 0, rdEarlyViol = 0, csHighRun = 0, lastCsGap = 0;
  int csFallTotal = 0, validTotal = 0, errTotal = 0;

  always @(posedge clk) begin
    if (rstN) begin
      if (!wrN) begin
        wrRun++; wrLowTotal++; afterWr = 1'b0;
      end else begin
        if (wrRun > 0) begin
          lastWrWidth = wrRun; wrRun = 0; afterWr = 1'b1; gap = 0;
        end
        if (afterWr) begin
          if (!rdN) begin lastGap = gap; afterWr = 1'b0; end
          else if (!csN) gap++;
        end
      end
      if (simWrMode && !reqEarly && !rdN && intN) rdEarlyViol++;
      if (csN) csHighRun++;
      else if (csHighRun > 0) begin
        lastCsGap = csHighRun; csHighRun = 0; csFallTotal++;
      end
      if (rspValid) validTotal++;
      if (rspError) errTotal++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // issue one request and wait for its response; returns 1 on rspValid
  task automatic runConv(input bit m, input bit e, input logic [7:0] d,
                         input bit o, input int lat, input bit stuck,
                         output bit gotValid, output logic [7:0] gData,
                         output bit gOvr, output bit released, output int recov);
    int w;
    @(negedge clk);
    simWrMode = m; simStuck = stuck; simData = d; simOvr = o; simLat = lat;
    reqMode = m; reqEarly = e; reqValid = 1'b1;
    w = 0;
    while (!reqReady && w < 5000) begin @(negedge clk); w++; end
    @(negedge clk);
    reqValid = 1'b0;
    w = 0;
    while (!rspValid && !rspError && w < 3000) begin @(negedge clk); w++; end
    if (w >= 3000) chk(1'b0, "R7", "response timeout", w, 0);
    gotValid = rspValid;
    gData    = rspData;
    gOvr     = rspOverRange;
    released = csN && rdN;
    recov = 0;
    while (!reqReady && recov < 1000) begin recov++; @(negedge clk); end
  endtask

  initial begin
    bit gv, gOvr, rel;
    logic [7:0] gd;
    int rc, v0, w0, e0, h0, c0;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk(csN && wrN && rdN, "R1", "lines high in reset", {csN, wrN, rdN}, 7);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    chk(rspValid == 1'b0 && rspError == 1'b0, "R1", "no response after reset",
        {rspValid, rspError}, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] vv;
      vv = VEC[i];
      v0 = validTotal; w0 = wrLowTotal; e0 = rdEarlyViol; h0 = earlyHitTotal;
      runConv(vv[18], vv[17], vv[16:9], vv[8], int'(vv[7:0]), 1'b0, gv, gd, gOvr, rel, rc);
      chk(gv, "R7", "valid pulse seen", gv, 1);
      chk(gd == vv[16:9], "R7", "result data", gd, vv[16:9]);
      chk(gOvr == vv[8], "R7", "over-range flag", gOvr, vv[8]);
      chk(validTotal - v0 == 1, "R7", "one valid per conversion", validTotal - v0, 1);
      chk(rel, "R8", "cs and rd released at result", rel, 1);
      chk(rc == RECOV, "R9", "recovery length", rc, RECOV);
      if (i > 0) chk(lastCsGap >= RECOV + 1, "R9", "cs high gap", lastCsGap, RECOV + 1);
      if (vv[18]) begin
        chk(lastWrWidth == WR_P, "R3", "write pulse width", lastWrWidth, WR_P);
        if (vv[17]) begin
          chk(lastGap == EARLY, "R5", "early read gap", lastGap, EARLY);
          chk(earlyHitTotal - h0 == 1, "R5", "read before timeout", earlyHitTotal - h0, 1);
        end else begin
          chk(rdEarlyViol == e0, "R4", "read before interrupt", rdEarlyViol - e0, 0);
        end
      end else begin
        chk(wrLowTotal == w0, "R6", "no write in read-only style", wrLowTotal - w0, 0);
      end
      chk(reqReady && csN && wrN && rdN, "R1", "idle lines after recovery",
          {reqReady, csN, wrN, rdN}, 15);
    end

    // R11: requests while busy are ignored
    c0 = csFallTotal; v0 = validTotal;
    @(negedge clk);
    simWrMode = 1'b1; simStuck = 1'b0; simData = 8'h5C; simOvr = 1'b0; simLat = 100;
    reqMode = 1'b1; reqEarly = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    reqMode = 1'b0; reqValid = 1'b1;
    repeat (30) @(negedge clk);
    chk(reqReady == 1'b0, "R11", "busy while converting", reqReady, 0);
    reqValid = 1'b0;
    repeat (100 + RECOV + 40) @(negedge clk);
    chk(csFallTotal - c0 == 1, "R11", "conversions started", csFallTotal - c0, 1);
    chk(validTotal - v0 == 1, "R11", "results returned", validTotal - v0, 1);
    chk(rspData == 8'h5C, "R11", "result of the accepted request", rspData, 8'h5C);

    // R10: converter never completes
    v0 = validTotal; e0 = errTotal;
    runConv(1'b1, 1'b0, 8'h11, 1'b0, 10, 1'b1, gv, gd, gOvr, rel, rc);
    chk(!gv, "R10", "no valid on abort", gv, 0);
    chk(errTotal - e0 == 1, "R10", "single error pulse", errTotal - e0, 1);
    chk(validTotal == v0, "R10", "valid count unchanged", validTotal - v0, 0);
    chk(rel, "R8", "lines released on abort", rel, 1);
    chk(rc == RECOV, "R9", "recovery after abort", rc, RECOV);

    // R10: read-only style stuck, then normal service resumes
    e0 = errTotal;
    runConv(1'b0, 1'b0, 8'h22, 1'b1, 10, 1'b1, gv, gd, gOvr, rel, rc);
    chk(errTotal - e0 == 1, "R10", "read-only style abort", errTotal - e0, 1);
    runConv(1'b0, 1'b0, 8'h96, 1'b1, 12, 1'b0, gv, gd, gOvr, rel, rc);
    chk(gv && gd == 8'h96, "R6", "service after abort", gd, 8'h96);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule